// File: doc/BRIEF.md
# Programmable Square-Wave Counter/Timer

This block is a down-counter with a programmable preset. It runs in one of two modes. In timer mode it acts as a programmable divider: it produces a continuous square wave whose high and low halves each last as many clock cycles as the preset value. In counter mode it counts down once from the preset to terminal count and then halts. The preset is loaded one byte at a time through two write strobes. Neither byte can be read back.

Nothing runs until the first start strobe. A start strobe always begins a fresh cycle from the preset that is current at that moment. A ready flag is raised for the interrupt logic. In timer mode it rises once per full square-wave period. In counter mode it rises at terminal count. A stop strobe always clears the ready flag. Only in counter mode does it also halt the count. In timer mode the wave keeps running.

Top module: `sqt_counter_timer`

## Requirements
- R1: While reset is held, and after it is released, `sq_o` and `ready_o` are 0 and the block is idle.
- R2: `wr_hi_i` stores `wr_data_i` as the preset's upper byte (bits 15:8) and `wr_lo_i` stores it as the lower byte (bits 7:0). The preset holds its value between writes. A preset of 0 or 1 behaves as 2.
- R3: Before the first start strobe, `sq_o` stays 0 and `ready_o` stays 0, whatever preset is written.
- R4: In timer mode, `sq_o` is 1 from the edge that samples the start strobe. It then alternates forever, and every high half and every low half lasts exactly P cycles, where P is the effective preset.
- R5: A preset written during a half-period does not change the length of that half. The next half uses the new value.
- R6: A start strobe while running abandons the current cycle. `sq_o` goes to 1 and a full new half of P cycles begins. A stop strobe in the same cycle as a start still clears `ready_o`.
- R7: In timer mode, `ready_o` rises on the edge that ends each low half, 2P cycles after the start. It does not rise at the end of a high half.
- R8: In timer mode, a stop strobe clears `ready_o` on the next edge. The square wave continues without any change to its timing.
- R9: In counter mode, `sq_o` is 1 for P cycles after the start edge. On the P-th edge `sq_o` falls and `ready_o` rises. After that nothing changes until the next start strobe.
- R10: In counter mode, a stop strobe halts the count where it is. `sq_o` holds its level and `ready_o` stays 0.
- R11: `mode_i` (1 = timer, 0 = counter) is sampled only by a start strobe. Changing it while the block runs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_hi_i | input | 1 | Write strobe for the preset upper byte |
| wr_lo_i | input | 1 | Write strobe for the preset lower byte |
| wr_data_i | input | 8 | Byte to write |
| mode_i | input | 1 | 1 = timer (square wave), 0 = counter (one shot) |
| start_i | input | 1 | Start strobe, one cycle |
| stop_i | input | 1 | Stop strobe, one cycle |
| sq_o | output | 1 | Square-wave / count-active output |
| ready_o | output | 1 | Ready flag to the interrupt logic |

## Verification
The bench measures each half of the wave in cycles for several presets, including the clamped values 0 and 1 and a preset that differs when its bytes are swapped. An off-by-one reload would show up as halves of P±1 cycles, and a byte-order error as a half of 513 cycles where 258 is expected. It rewrites the preset in the middle of a high half and restarts during a low half. A design that reloads immediately would cut the current half short, and one that ignores a restart would stretch it. It also checks that the ready flag stays low at the end of a high half and that a stop in timer mode leaves the wave running. A design that sets the flag at every zero crossing, or that halts the timer on stop, fails these checks. In counter mode the bench checks that the count halts on stop and freezes at terminal count, and that changing the mode input while running changes nothing.

// File: rtl/sqt_pkg.sv
package sqt_pkg;

  typedef enum logic {
    CT_COUNTER = 1'b0,
    CT_TIMER   = 1'b1
  } ct_mode_e;

  localparam int unsigned SQT_MIN_PRESET = 2;

endpackage

// File: rtl/sqt_rst_sync.sv
module sqt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/sqt_preset_regs.sv
module sqt_preset_regs import sqt_pkg::*; #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned CNT_W = BYTE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  preset_o
);

  logic [CNT_W-1:0] raw_value;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] byte_d;

    always_comb begin
      byte_d = byte_q;
      if (lane_we_i[g]) begin
        byte_d = wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
      end else if (lane_we_i[g]) begin
        byte_q <= byte_d;
      end
    end

    assign raw_value[g*BYTE_W +: BYTE_W] = byte_q;
  end

  always_comb begin
    if (raw_value < CNT_W'(SQT_MIN_PRESET)) begin
      preset_o = CNT_W'(SQT_MIN_PRESET);
    end else begin
      preset_o = raw_value;
    end
  end

  AST_PRESET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_we_i == '0) |=> $stable(preset_o)) else $error("preset moved without write"); // R2

endmodule

// File: rtl/sqt_down_counter.sv
module sqt_down_counter import sqt_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic             sq_o,
  output logic             evt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             sq_q, sq_d;
  ct_mode_e         mode_q, mode_d;
  logic             at_end;
  logic             evt;
  logic             upd_en;

  assign at_end = (cnt_q == CNT_W'(1));
  assign upd_en = start_i | stop_i | run_q;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    sq_d   = sq_q;
    mode_d = mode_q;
    evt    = 1'b0;
    if (start_i) begin
      run_d  = 1'b1;
      cnt_d  = preset_i;
      sq_d   = 1'b1;
      mode_d = ct_mode_e'(mode_i);
    end else if (stop_i && (mode_q == CT_COUNTER)) begin
      run_d = 1'b0;
    end else if (run_q) begin
      if (at_end) begin
        if (mode_q == CT_TIMER) begin
          cnt_d = preset_i;
          sq_d  = ~sq_q;
          evt   = ~sq_q;
        end else begin
          cnt_d = '0;
          sq_d  = 1'b0;
          run_d = 1'b0;
          evt   = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      sq_q   <= 1'b0;
      mode_q <= CT_COUNTER;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      sq_q   <= sq_d;
      mode_q <= mode_d;
    end
  end

  assign sq_o  = sq_q;
  assign evt_o = evt;

  AST_RUN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q != '0)) else $error("running with zero count"); // R4
  AST_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (sq_o && run_q)) else $error("start did not raise output"); // R6
  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> ($stable(sq_o) && $stable(cnt_q))) else $error("idle state moved"); // R3
  AST_TIMER_NO_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && (mode_q == CT_TIMER) && !start_i) |=> run_q) else $error("timer halted"); // R8
  AST_CTR_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && (mode_q == CT_COUNTER) && !start_i) |=> (!run_q && !sq_o)) else $error("counter kept running"); // R9
  AST_CTR_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i && (mode_q == CT_COUNTER)) |=> ($stable(sq_o) && !run_q)) else $error("stop did not halt"); // R10

endmodule

// File: rtl/sqt_ready_flag.sv
module sqt_ready_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic ready_o
);

  logic flag_q, flag_d;
  logic flag_en;

  assign flag_en = set_i | clr_i;

  always_comb begin
    flag_d = flag_q;
    if (set_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign ready_o = flag_q;

  AST_RDY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(set_i)) else $error("flag rose without event"); // R7
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !ready_o) else $error("stop left flag set"); // R8

endmodule

// File: rtl/sqt_counter_timer.sv
module sqt_counter_timer import sqt_pkg::*; #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned RST_STAGE = 2,
  localparam int unsigned LANES    = 2,
  localparam int unsigned CNT_W    = BYTE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              mode_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sq_o,
  output logic              ready_o
);

  logic             rst_n_int;
  logic [CNT_W-1:0] preset;
  logic             cycle_evt;

  sqt_rst_sync #(
    .STAGES (RST_STAGE)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  sqt_preset_regs #(
    .BYTE_W (BYTE_W),
    .LANES  (LANES)
  ) u_preset (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .lane_we_i ({wr_hi_i, wr_lo_i}),
    .wr_data_i (wr_data_i),
    .preset_o  (preset)
  );

  sqt_down_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .mode_i   (mode_i),
    .preset_i (preset),
    .sq_o     (sq_o),
    .evt_o    (cycle_evt)
  );

  sqt_ready_flag u_ready (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .set_i   (cycle_evt),
    .clr_i   (stop_i),
    .ready_o (ready_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n_int |-> (!sq_o && !ready_o)) else $error("outputs active in reset"); // R1

endmodule

// File: tb/sqt_counter_timer_bench.sv
`timescale 1ns/1ps
module sqt_counter_timer_bench;

  logic       clk;
  logic       rst_n;
  logic       wr_hi, wr_lo;
  logic [7:0] wr_data;
  logic       mode;
  logic       start, stop;
  logic       sq, ready;

  int tests_run;
  int tests_failed;
  int wd_cycles;
  localparam int MAXW = 2000;

  // {mode (1 = timer), preset}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 16'd2}, {1'b1, 16'd3}, {1'b1, 16'd17}, {1'b1, 16'h0100},
    {1'b1, 16'd0}, {1'b0, 16'd1}, {1'b0, 16'd9}, {1'b0, 16'h0102}
  };

  sqt_counter_timer u_sqt_counter_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_hi_i   (wr_hi),
    .wr_lo_i   (wr_lo),
    .wr_data_i (wr_data),
    .mode_i    (mode),
    .start_i   (start),
    .stop_i    (stop),
    .sq_o      (sq),
    .ready_o   (ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int eff(input int p);
    return (p < 2) ? 2 : p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 150000) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", wd_cycles);
      summary();
    end
  end

  task automatic write_preset(input logic [15:0] v);
    @(negedge clk); wr_hi = 1'b1; wr_data = v[15:8];
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = v[7:0];
    @(negedge clk); wr_lo = 1'b0;
  endtask

  // returns at the first sample after the start edge
  task automatic do_start(input logic m, input logic with_stop);
    @(negedge clk); mode = m; start = 1'b1; stop = with_stop;
    @(negedge clk); start = 1'b0; stop = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic measure(input logic v, output int n);
    n = 0;
    while ((sq === v) && (n < MAXW)) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int hi_n, lo_n, bad;
    tests_run = 0; tests_failed = 0; wd_cycles = 0;
    rst_n = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0; wr_data = '0;
    mode = 1'b0; start = 1'b0; stop = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 sq in reset", int'(sq), 0);
    chk("R1 ready in reset", int'(ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sq after reset", int'(sq), 0);

    // R3: nothing runs before the first start
    write_preset(16'd5);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sq !== 1'b0 || ready !== 1'b0) bad++;
    end
    chk("R3 idle before start", bad, 0);

    // vector table: R2 R4 R7 R9
    for (int v = 0; v < 8; v++) begin
      int p;
      p = eff(int'(VEC[v][15:0]));
      write_preset(VEC[v][15:0]);
      do_start(VEC[v][16], 1'b1);
      measure(1'b1, hi_n);
      chk($sformatf("R2 R4 high half vec%0d", v), hi_n, p);
      if (VEC[v][16]) begin
        chk($sformatf("R7 no flag at high end vec%0d", v), int'(ready), 0);
        measure(1'b0, lo_n);
        chk($sformatf("R4 low half vec%0d", v), lo_n, p);
        chk($sformatf("R7 flag after full cycle vec%0d", v), int'(ready), 1);
      end else begin
        chk($sformatf("R9 flag at terminal vec%0d", v), int'(ready), 1);
        repeat (2 * p + 3) @(negedge clk);
        chk($sformatf("R9 halted sq vec%0d", v), int'(sq), 0);
        chk($sformatf("R9 halted flag vec%0d", v), int'(ready), 1);
      end
    end

    // R8: stop in timer mode clears flag, wave keeps its timing
    write_preset(16'd6);
    do_start(1'b1, 1'b1);
    measure(1'b1, hi_n);
    measure(1'b0, lo_n);
    chk("R7 flag set before stop", int'(ready), 1);
    pulse_stop();
    chk("R8 stop clears flag", int'(ready), 0);
    measure(1'b1, hi_n);
    chk("R8 high remainder after stop", hi_n, 4);
    chk("R7 flag stays clear at high end", int'(ready), 0);
    measure(1'b0, lo_n);
    chk("R8 low half after stop", lo_n, 6);
    chk("R7 flag sets again", int'(ready), 1);

    // R5: preset change mid-half
    write_preset(16'd8);
    do_start(1'b1, 1'b1);
    write_preset(16'd3);
    measure(1'b1, hi_n);
    chk("R5 current half keeps old preset", hi_n, 5);
    measure(1'b0, lo_n);
    chk("R5 next half uses new preset", lo_n, 3);

    // R6: restart during a low half
    write_preset(16'd5);
    do_start(1'b1, 1'b1);
    measure(1'b1, hi_n);
    do_start(1'b1, 1'b0);
    chk("R6 restart raises output", int'(sq), 1);
    measure(1'b1, hi_n);
    chk("R6 restart full high half", hi_n, 5);
    chk("R6 no flag after aborted cycle", int'(ready), 0);

    // R11: mode input changed while running
    write_preset(16'd4);
    do_start(1'b1, 1'b1);
    mode = 1'b0;
    measure(1'b1, hi_n);
    measure(1'b0, lo_n);
    chk("R11 timer continues after mode change", lo_n, 4);
    chk("R11 sq high again", int'(sq), 1);

    // R10: stop in counter mode halts the count
    write_preset(16'd20);
    do_start(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    pulse_stop();
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sq !== 1'b1 || ready !== 1'b0) bad++;
    end
    chk("R10 counter halted by stop", bad, 0);

    summary();
  end

endmodule